// File: doc/BRIEF.md
# Power-Fail Interrupt Filter

This block turns a digital power-fail comparator flag into a clean, active-low interrupt for a processor. The flag reports that the monitored supply has dropped below its trip point. A prescaler divides the system clock into a slow sample tick of roughly 33 µs. The flag is read only on that tick. A trip is recognised only after a run of consecutive low samples, so brief dips and noise between ticks do not reach the processor.

Once a trip is recognised, the interrupt line goes low. It stays low for a guaranteed minimum number of ticks. It is released on the first high sample after that minimum, or when an internal timeout expires while the supply is still low. After a timeout, the block re-arms only when a high sample has been seen. While the main supply is not yet good, for example during power-up, trips are held back from the interrupt line. All durations are counted in ticks and set by parameters.

Top module: `pfi_filter`

## Requirements
- R1: After synchronous active-high reset, `nmi_n_o` is high and the low-sample count is zero, so a full run of `LOW_SAMPLES` fresh low samples is needed before a pulse.
- R2: The sense flag is looked at only in the cycle of each sample tick, and ticks come once every `CLK_DIV` clock cycles. The first tick is `CLK_DIV` cycles after reset is released. A flag level held between ticks has no effect.
- R3: When the `LOW_SAMPLES`-th consecutive tick samples `below_trip_i`=1 with `supply_ok_i`=1, `nmi_n_o` goes low on the clock edge that follows that tick.
- R4: A tick that samples `below_trip_i`=0 before the run is complete clears the count, and no pulse follows.
- R5: Once low, `nmi_n_o` stays low for at least `MIN_TICKS` ticks. High samples at earlier ticks do not end the pulse.
- R6: From the `MIN_TICKS`-th tick of the pulse onward, the first tick that samples `below_trip_i`=0 returns `nmi_n_o` high on that tick's edge.
- R7: At the `TIMEOUT_TICKS`-th tick of the pulse, `nmi_n_o` returns high even if the input is still low.
- R8: After a pulse that ended by timeout, no new pulse starts until a tick has sampled the input high and a fresh run of `LOW_SAMPLES` low samples has followed.
- R9: While `supply_ok_i`=0, no pulse starts. If the low run is already complete when `supply_ok_i` rises, the pulse starts on the edge after the rise is seen.
- R10: A pulse that has started is not cut short when `supply_ok_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| below_trip_i | input | 1 | Comparator flag: 1 = sense input below trip point |
| supply_ok_i | input | 1 | Main supply is within tolerance |
| nmi_n_o | output | 1 | Registered interrupt, active low |

## Verification
The low-sample count, the pulse tick count and the state are all hidden from the ports. Each one can only show up as a pulse on `nmi_n_o` that starts at the wrong time, lasts the wrong time, or is missing. A count that is off by one, or one that fails to clear, moves the falling edge or the rising edge by a whole tick period. This appears within one tick of where a correct design would switch. A wrong re-arm state shows up only later, as a spurious second pulse or a missing one after a timeout.

// File: rtl/pfi_pkg.sv
package pfi_pkg;
  typedef enum logic [1:0] {
    PF_IDLE   = 2'd0,
    PF_ACTIVE = 2'd1,
    PF_REARM  = 2'd2
  } pf_state_t;
endpackage

// File: rtl/pfi_tick_gen.sv
module pfi_tick_gen #(
  parameter int CLK_DIV = 3300
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst)                div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == LAST);

  generate
    if (CLK_DIV > 1) begin : g_chk
      // R2: ticks are isolated single-cycle strobes
      a_r2_single_tick: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/pfi_low_count.sv
module pfi_low_count #(
  parameter int LOW_SAMPLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic below_i,
  output logic trip_o
);
  localparam int NW = $clog2(LOW_SAMPLES + 1);
  localparam logic [NW-1:0] FULL = NW'(LOW_SAMPLES);

  logic [NW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (tick_i) begin
      if (!below_i)          run_q <= '0;
      else if (run_q != FULL) run_q <= run_q + 1'b1;
    end
  end

  assign trip_o = (run_q == FULL);

  // R4: a high sample clears the run
  a_r4_clear_on_high: assert property (@(posedge clk) disable iff (rst)
    (tick_i && !below_i) |=> (run_q == '0));
  // R3: the run saturates at the trip length
  a_r3_run_bounded: assert property (@(posedge clk) disable iff (rst)
    run_q <= FULL);
  // R2: the run changes only on a tick
  a_r2_run_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(run_q));
endmodule

// File: rtl/pfi_pulse_ctl.sv
module pfi_pulse_ctl
  import pfi_pkg::*;
#(
  parameter int MIN_TICKS     = 7,
  parameter int TIMEOUT_TICKS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic below_i,
  input  logic trip_i,
  input  logic supply_ok_i,
  output logic nmi_n_o
);
  localparam int PW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [PW-1:0] MIN_V = PW'(MIN_TICKS);
  localparam logic [PW-1:0] TO_V  = PW'(TIMEOUT_TICKS);

  pf_state_t     st_q, st_d;
  logic [PW-1:0] pc_q, pc_d, pc_inc;
  logic          nmi_n_q;

  assign pc_inc = pc_q + 1'b1;

  always_comb begin
    st_d = st_q;
    pc_d = pc_q;
    unique case (st_q)
      PF_IDLE: if (trip_i && supply_ok_i) begin
        st_d = PF_ACTIVE;
        pc_d = '0;
      end
      PF_ACTIVE: if (tick_i) begin
        pc_d = pc_inc;
        if (pc_inc >= TO_V)                     st_d = below_i ? PF_REARM : PF_IDLE;
        else if (pc_inc >= MIN_V && !below_i)   st_d = PF_IDLE;
      end
      PF_REARM: if (tick_i && !below_i) st_d = PF_IDLE;
      default: st_d = PF_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= PF_IDLE;
      pc_q    <= '0;
      nmi_n_q <= 1'b1;
    end else begin
      st_q    <= st_d;
      pc_q    <= pc_d;
      nmi_n_q <= (st_d != PF_ACTIVE);
    end
  end

  assign nmi_n_o = nmi_n_q;

  // R9: a pulse starts only with supply good and a completed run
  a_r9_start_gated: assert property (@(posedge clk) disable iff (rst)
    $fell(nmi_n_o) |-> ($past(supply_ok_i) && $past(trip_i)));
  // R5: release never comes before the minimum width
  a_r5_min_width: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_n_o) |-> ($past(pc_q) >= PW'(MIN_TICKS - 1)));
  // R7: the pulse count never reaches the timeout while low
  a_r7_timeout_bound: assert property (@(posedge clk) disable iff (rst)
    !nmi_n_o |-> (pc_q < TO_V));
  // R8: no new pulse from the re-arm state without a high sample
  a_r8_rearm_hold: assert property (@(posedge clk) disable iff (rst)
    (st_q == PF_REARM && !(tick_i && !below_i)) |=> nmi_n_o);
  // R10: supply loss does not end an active pulse between ticks
  a_r10_hold_low: assert property (@(posedge clk) disable iff (rst)
    (!nmi_n_o && !tick_i) |=> !nmi_n_o);
endmodule

// File: rtl/pfi_filter.sv
module pfi_filter #(
  parameter int CLK_DIV       = 3300,
  parameter int LOW_SAMPLES   = 3,
  parameter int MIN_TICKS     = 7,
  parameter int TIMEOUT_TICKS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic below_trip_i,
  input  logic supply_ok_i,
  output logic nmi_n_o
);
  logic tick, trip;

  pfi_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  pfi_low_count #(.LOW_SAMPLES(LOW_SAMPLES)) u_run (
    .clk(clk), .rst(rst), .tick_i(tick), .below_i(below_trip_i), .trip_o(trip)
  );

  pfi_pulse_ctl #(.MIN_TICKS(MIN_TICKS), .TIMEOUT_TICKS(TIMEOUT_TICKS)) u_pulse (
    .clk(clk), .rst(rst), .tick_i(tick), .below_i(below_trip_i), .trip_i(trip),
    .supply_ok_i(supply_ok_i), .nmi_n_o(nmi_n_o)
  );

  // R1: output is released high right after reset
  a_r1_reset_high: assert property (@(posedge clk) $past(rst) |-> nmi_n_o);
endmodule

// File: tb/sim_pfi_filter.sv
module sim_pfi_filter;
  localparam int DIV = 4;
  localparam int N   = 3;
  localparam int MN  = 7;
  localparam int TO  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic below = 1'b0;
  logic ok = 1'b1;
  logic nmi_n;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  // bench model: 0 idle, 1 active, 2 re-arm
  int m_st = 0;
  int m_run = 0;
  int m_pc = 0;

  always #5 clk = ~clk;

  pfi_filter #(.CLK_DIV(DIV), .LOW_SAMPLES(N), .MIN_TICKS(MN), .TIMEOUT_TICKS(TO)) u0 (
    .clk(clk), .rst(rst), .below_trip_i(below), .supply_ok_i(ok), .nmi_n_o(nmi_n)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=timeout exp=completion");
      summary();
    end
  end

  task automatic check(input string tag, input logic exp);
    n_chk++;
    if (nmi_n !== exp) begin
      n_bad++;
      $display("FAIL %s: nmi_n act=%b exp=%b (t=%0t)", tag, nmi_n, exp, $time);
    end
  endtask

  function automatic void model(input bit b, input bit s_ok);
    if (m_st == 0 && m_run >= N && s_ok) begin m_st = 1; m_pc = 0; end
    if (m_st == 1) begin
      m_pc++;
      if (m_pc >= TO)            m_st = b ? 2 : 0;
      else if (m_pc >= MN && !b) m_st = 0;
    end else if (m_st == 2 && !b) m_st = 0;
    m_run = b ? ((m_run < N) ? m_run + 1 : N) : 0;
    if (m_st == 0 && m_run >= N && s_ok) begin m_st = 1; m_pc = 0; end
  endfunction

  // one tick period; starts and ends at the negedge after a tick edge + 1
  task automatic step(input string tag, input bit b, input bit s_ok, input bit glitch);
    ok = s_ok;
    if (!glitch) begin
      below = b;
      repeat (DIV) @(posedge clk);
    end else begin
      below = !b;
      repeat (DIV - 2) @(posedge clk);
      @(negedge clk) below = b;
      @(posedge clk);
      @(negedge clk) below = !b;
      @(posedge clk);
    end
    @(negedge clk);
    model(b, s_ok);
    check(tag, (m_st == 1) ? 1'b0 : 1'b1);
  endtask

  task automatic settle(input string tag);
    for (int i = 0; i < 16; i++) step(tag, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 1'b1);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", 1'b1);

    // R3/R4: runs of k lows then high
    for (int k = 1; k <= 5; k++) begin
      for (int i = 0; i < k; i++) step((k < N) ? "R4" : "R3", 1'b1, 1'b1, 1'b0);
      settle("R6");
    end

    // R4: broken runs
    step("R4", 1'b1, 1'b1, 1'b0); step("R4", 1'b1, 1'b1, 1'b0);
    step("R4", 1'b0, 1'b1, 1'b0);
    step("R4", 1'b1, 1'b1, 1'b0); step("R4", 1'b1, 1'b1, 1'b0);
    settle("R4");

    // R2: levels between ticks are ignored
    for (int i = 0; i < 6; i++) step("R2", 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 5; i++) step("R2", 1'b1, 1'b1, 1'b1);
    settle("R2");

    // R5/R6/R7: return high after j extra lows
    for (int j = 0; j <= 15; j++) begin
      for (int i = 0; i < N + j; i++) step((j < TO) ? "R5" : "R7", 1'b1, 1'b1, 1'b0);
      settle("R6");
    end

    // R8: long low, then re-arm
    for (int i = 0; i < 30; i++) step("R8", 1'b1, 1'b1, 1'b0);
    step("R8", 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) step("R8", 1'b1, 1'b1, 1'b0);
    settle("R8");

    // R9: supply not good blocks, rise releases
    for (int i = 0; i < 6; i++) step("R9", 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 14; i++) step("R9", 1'b1, 1'b1, 1'b0);
    settle("R9");
    for (int i = 0; i < 2; i++) step("R9", 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step("R9", 1'b1, 1'b1, 1'b0);
    settle("R9");

    // R10: supply loss mid-pulse
    for (int i = 0; i < N + 2; i++) step("R10", 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) step("R10", 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 12; i++) step("R10", 1'b0, 1'b0, 1'b0);
    settle("R10");

    done = 1;
    summary();
  end
endmodule